// File: doc/BRIEF.md
# Clock Lock Monitor with Loop Bandwidth Select

This block watches a clock PLL from the digital side. A fast sampling clock receives the divided reference clock and the divided feedback clock. Each of them passes through a synchronizer, and the block then finds its rising edges. On each phase-detector cycle the block counts, in sampling cycles, how far apart the two rising edges fall. A large gap sets a loss-of-lock flag. Only a small gap clears the flag again, and any gap between the two limits leaves the flag as it is. A rising edge on one clock with no matching edge on the other within a timeout window counts as a large gap. This covers a clock that has stopped.

The block also drives a loop-bandwidth select line. That line asks for narrow bandwidth only when all of these hold: the narrow request is set, the initialization input allows narrow mode, and a run of consecutive comparisons has kept the loop locked. A comparison that finds loss of lock returns the loop to wide bandwidth at once.

Top module: `lock_monitor`

## Requirements
- R1: After reset, `lock_lost_o` is 1, `bw_narrow_o` is 0 (wide bandwidth), and the good-comparison run count is 0.
- R2: Both clock inputs pass through `SYNC_STAGES` (default 2) flops before rising-edge detection. A comparison starts at the first rising edge on either clock and ends at the next rising edge of the other clock. The separation is the number of sampling cycles between those two edges, and edges that arrive in the same cycle give 0. Rising edges of the leading clock that arrive while a comparison is open are ignored, and the edge that ends a comparison does not open a new one. `lock_lost_o` takes the outcome on the third sampling edge after the one that first samples the later input edge.
- R3: A separation greater than `SET_CYC` (default 8) sets `lock_lost_o` to 1.
- R4: A separation less than `CLR_CYC` (default 4) sets `lock_lost_o` to 0.
- R5: A separation from `CLR_CYC` to `SET_CYC` inclusive leaves `lock_lost_o` unchanged. `lock_lost_o` changes only through a comparison.
- R6: If the other clock shows no rising edge within `TIMEOUT_CYC` (default 64) cycles of the opening edge, the comparison ends as a loss of lock and `lock_lost_o` becomes 1.
- R7: While `init_en_i` is 0, `bw_narrow_o` is 0 whatever `narrow_req_i` is.
- R8: While `narrow_req_i` is 0, `bw_narrow_o` is 0.
- R9: `bw_narrow_o` is 1 (narrow) only when `init_en_i` is 1, `narrow_req_i` is 1, and each of the last `GOOD_RUN` (default 8) comparisons left `lock_lost_o` at 0. The run count stops at `GOOD_RUN` and keeps counting while the request is low. Narrow mode is therefore granted at once when the request returns after a long locked stretch.
- R10: A comparison that leaves `lock_lost_o` at 1 clears the run count to 0, and `bw_narrow_o` is 0 from the same cycle in which `lock_lost_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div_i | input | 1 | Divided reference clock (asynchronous) |
| fb_div_i | input | 1 | Divided feedback clock (asynchronous) |
| narrow_req_i | input | 1 | 1 requests narrow loop bandwidth |
| init_en_i | input | 1 | 0 forces wide bandwidth; 1 allows narrow mode |
| lock_lost_o | output | 1 | 1 = loss of lock, 0 = locked |
| bw_narrow_o | output | 1 | 1 = narrow bandwidth, 0 = wide bandwidth |

## Verification
The bench runs the clock pair with a feedback lag of 0, 1, 6 and 10 cycles, and with a feedback lead of 2 cycles. These patterns separate the clear band, the hold band and the set band, and they show that the block works in both edge orders. Each hold-band run follows both a locked and an unlocked state, which shows that this band really keeps its prior state. A run with the feedback stopped exercises the timeout path. Toggling the initialization and request inputs while the run count is full shows the forcing to wide bandwidth and the immediate return to narrow.

// File: rtl/lkmon_pkg.sv
package lkmon_pkg;
   typedef enum logic {
      LEAD_REF = 1'b0,
      LEAD_FB  = 1'b1
   } lead_e;

   localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/lkmon_edge_sync.sv
module lkmon_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   generate
      if (STAGES < lkmon_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
         $error("lkmon_edge_sync: STAGES below minimum");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/lkmon_skew_meter.sv
module lkmon_skew_meter
   import lkmon_pkg::*;
#(
   parameter int TIMEOUT_CYC = 64,
   parameter int CNT_W       = $clog2(TIMEOUT_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_rise_i,
   input  logic             fb_rise_i,
   output logic             done_o,
   output logic [CNT_W-1:0] sep_o,
   output logic             late_o
);
   localparam logic [CNT_W-1:0] AGE_LIMIT = CNT_W'(TIMEOUT_CYC);

   logic             armed_q;
   lead_e            lead_q;
   logic [CNT_W-1:0] age_q;
   logic             other_rise;

   assign other_rise = (lead_q == LEAD_REF) ? fb_rise_i : ref_rise_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         lead_q  <= LEAD_REF;
         age_q   <= '0;
         done_o  <= 1'b0;
         sep_o   <= '0;
         late_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         late_o <= 1'b0;
         if (!armed_q) begin
            if (ref_rise_i && fb_rise_i) begin
               done_o <= 1'b1;
               sep_o  <= '0;
            end else if (ref_rise_i || fb_rise_i) begin
               armed_q <= 1'b1;
               lead_q  <= ref_rise_i ? LEAD_REF : LEAD_FB;
               age_q   <= CNT_W'(1);
            end
         end else if (other_rise) begin
            armed_q <= 1'b0;
            done_o  <= 1'b1;
            sep_o   <= age_q;
         end else if (age_q == AGE_LIMIT) begin
            armed_q <= 1'b0;
            done_o  <= 1'b1;
            late_o  <= 1'b1;
            sep_o   <= age_q;
         end else begin
            age_q <= age_q + CNT_W'(1);
         end
      end
   end

   // R6: an open comparison never runs past the timeout window
   assert_age_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (age_q <= AGE_LIMIT));
endmodule

// File: rtl/lkmon_lock_track.sv
module lkmon_lock_track #(
   parameter int SET_CYC  = 8,
   parameter int CLR_CYC  = 4,
   parameter int GOOD_RUN = 8,
   parameter int CNT_W    = 7,
   parameter int RUN_W    = $clog2(GOOD_RUN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_i,
   input  logic [CNT_W-1:0] sep_i,
   input  logic             late_i,
   output logic             lost_o,
   output logic             run_full_o
);
   localparam logic [CNT_W-1:0] SET_LIM = CNT_W'(SET_CYC);
   localparam logic [CNT_W-1:0] CLR_LIM = CNT_W'(CLR_CYC);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(GOOD_RUN);

   logic             lost_q;
   logic [RUN_W-1:0] good_q;
   logic             lost_nxt;

   always_comb begin
      if (late_i || (sep_i > SET_LIM)) lost_nxt = 1'b1;
      else if (sep_i < CLR_LIM)        lost_nxt = 1'b0;
      else                             lost_nxt = lost_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lost_q <= 1'b1;
         good_q <= '0;
      end else if (done_i) begin
         lost_q <= lost_nxt;
         if (lost_nxt)              good_q <= '0;
         else if (good_q != RUN_MAX) good_q <= good_q + RUN_W'(1);
      end
   end

   assign lost_o     = lost_q;
   assign run_full_o = (good_q == RUN_MAX);

   // R5: the flag only moves when a comparison completes
   assert_hold_no_cmp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !done_i |=> $stable(lost_q));
   // R6: a timed-out comparison reports loss of lock
   assert_late_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && late_i) |=> lost_q);
   // R9: the run count saturates at its limit
   assert_run_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      good_q <= RUN_MAX);
   // R10: no good-comparison run survives while unlocked
   assert_run_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lost_q |-> (good_q == '0));
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
   parameter int SYNC_STAGES = 2,
   parameter int SET_CYC     = 8,
   parameter int CLR_CYC     = 4,
   parameter int TIMEOUT_CYC = 64,
   parameter int GOOD_RUN    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_div_i,
   input  logic fb_div_i,
   input  logic narrow_req_i,
   input  logic init_en_i,
   output logic lock_lost_o,
   output logic bw_narrow_o
);
   localparam int CNT_W  = $clog2(TIMEOUT_CYC + 1);
   localparam int N_CLKS = 2;

   generate
      if (CLR_CYC >= SET_CYC) begin : g_bad_band
         $error("lock_monitor: CLR_CYC must be below SET_CYC");
      end
      if (SET_CYC >= TIMEOUT_CYC) begin : g_bad_timeout
         $error("lock_monitor: TIMEOUT_CYC must exceed SET_CYC");
      end
      if (GOOD_RUN < 1) begin : g_bad_run
         $error("lock_monitor: GOOD_RUN must be at least 1");
      end
   endgenerate

   logic [N_CLKS-1:0] raw_clks;
   logic [N_CLKS-1:0] rises;
   logic              cmp_done;
   logic [CNT_W-1:0]  cmp_sep;
   logic              cmp_late;
   logic              run_full;

   assign raw_clks = {fb_div_i, ref_div_i};

   generate
      for (genvar g = 0; g < N_CLKS; g++) begin : g_sync
         lkmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (raw_clks[g]),
            .rise_o  (rises[g])
         );
      end
   endgenerate

   lkmon_skew_meter #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_rise_i (rises[0]),
      .fb_rise_i  (rises[1]),
      .done_o     (cmp_done),
      .sep_o      (cmp_sep),
      .late_o     (cmp_late)
   );

   lkmon_lock_track #(
      .SET_CYC(SET_CYC), .CLR_CYC(CLR_CYC), .GOOD_RUN(GOOD_RUN), .CNT_W(CNT_W)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (cmp_done),
      .sep_i      (cmp_sep),
      .late_i     (cmp_late),
      .lost_o     (lock_lost_o),
      .run_full_o (run_full)
   );

   assign bw_narrow_o = init_en_i & narrow_req_i & run_full & ~lock_lost_o;

   // R10: a far comparison drops narrow bandwidth on the very next cycle
   assert_far_drops_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_done && (cmp_late || (cmp_sep > CNT_W'(SET_CYC)))) |=> !bw_narrow_o);
   // R3: a far comparison raises the loss-of-lock flag
   assert_far_sets_lost_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_done && (cmp_sep > CNT_W'(SET_CYC))) |=> lock_lost_o);
endmodule

// File: tb/lock_monitor_tb.sv
module lock_monitor_tb;
   localparam int SET_CYC  = 8;
   localparam int CLR_CYC  = 4;
   localparam int TO_CYC   = 64;
   localparam int RUN      = 8;
   localparam int PER      = 24;
   localparam int LAT      = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_div = 1'b0;
   logic fb_div = 1'b0;
   logic narrow_req = 1'b1;
   logic init_en = 1'b1;
   logic lock_lost;
   logic bw_narrow;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   lock_monitor u_dut (
      .clk(clk), .rst_n(rst_n), .ref_div_i(ref_div), .fb_div_i(fb_div),
      .narrow_req_i(narrow_req), .init_en_i(init_en),
      .lock_lost_o(lock_lost), .bw_narrow_o(bw_narrow)
   );

   // behavioural reference model
   bit m_ref_prev, m_fb_prev, m_open, m_lead_ref, m_lost;
   int m_t0, m_good, m_now;
   bit lost_pipe[$];
   int good_pipe[$];

   task automatic model_reset();
      m_ref_prev = 0; m_fb_prev = 0; m_open = 0; m_lead_ref = 0;
      m_lost = 1; m_good = 0; m_now = 0; m_t0 = 0;
      lost_pipe.delete(); good_pipe.delete();
      for (int i = 0; i < LAT; i++) begin
         lost_pipe.push_back(1'b1);
         good_pipe.push_back(0);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         bit rr, fr, got, far;
         int gap;
         bit exp_lost, exp_bw;
         int exp_good;
         rr = ref_div && !m_ref_prev;
         fr = fb_div && !m_fb_prev;
         m_ref_prev = ref_div;
         m_fb_prev = fb_div;
         got = 0; far = 0; gap = 0;
         m_now++;
         if (!m_open) begin
            if (rr && fr) begin
               got = 1; gap = 0;
            end else if (rr || fr) begin
               m_open = 1; m_lead_ref = rr; m_t0 = m_now;
            end
         end else begin
            gap = m_now - m_t0;
            if ((m_lead_ref && fr) || (!m_lead_ref && rr)) begin
               got = 1; m_open = 0;
            end else if (gap == TO_CYC) begin
               got = 1; far = 1; m_open = 0;
            end
         end
         if (got) begin
            if (far || gap > SET_CYC) m_lost = 1;
            else if (gap < CLR_CYC)   m_lost = 0;
            if (m_lost) m_good = 0;
            else if (m_good < RUN) m_good++;
         end
         lost_pipe.push_back(m_lost);
         good_pipe.push_back(m_good);
         exp_lost = lost_pipe.pop_front();
         exp_good = good_pipe.pop_front();
         #2;
         exp_bw = init_en && narrow_req && (exp_good == RUN) && !exp_lost;
         checks++;
         if (lock_lost !== exp_lost) begin
            fails++;
            $display("FAIL R3/R4/R5/R6 cycle %0d lock_lost=%b expected %b", cyc, lock_lost, exp_lost);
         end
         checks++;
         if (bw_narrow !== exp_bw) begin
            fails++;
            $display("FAIL R7/R8/R9/R10 cycle %0d bw_narrow=%b expected %b", cyc, bw_narrow, exp_bw);
         end
      end
   end

   task automatic check_bit(string req, logic actual, logic expected);
      checks++;
      if (actual !== expected) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", req, actual, expected);
      end
   endtask

   task automatic run_wave(int n, int skew, bit fb_on);
      for (int i = 0; i < n; i++) begin
         int ph, fph;
         @(negedge clk);
         ph = cyc % PER;
         fph = (((cyc - skew) % PER) + PER) % PER;
         ref_div = (ph < PER / 2);
         fb_div = fb_on && (fph < PER / 2);
         cyc++;
      end
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;
      check_bit("R1 lock_lost after reset", lock_lost, 1'b1);
      check_bit("R1 bw_narrow after reset", bw_narrow, 1'b0);

      run_wave(20 * PER, 1, 1);                // small lag: lock, then narrow
      check_bit("R4 lag 1 clears lock", lock_lost, 1'b0);
      check_bit("R9 narrow after good run", bw_narrow, 1'b1);

      run_wave(20 * PER, 6, 1);                // hold band from locked
      check_bit("R5 lag 6 holds locked", lock_lost, 1'b0);

      run_wave(20 * PER, 10, 1);               // large lag
      check_bit("R3 lag 10 sets loss", lock_lost, 1'b1);
      check_bit("R10 wide after loss", bw_narrow, 1'b0);

      run_wave(20 * PER, 6, 1);                // hold band from unlocked
      check_bit("R5 lag 6 holds unlocked", lock_lost, 1'b1);

      run_wave(20 * PER, -2, 1);               // feedback leads
      check_bit("R2 feedback lead 2 clears lock", lock_lost, 1'b0);
      check_bit("R9 narrow with feedback leading", bw_narrow, 1'b1);

      init_en = 1'b0;
      run_wave(5 * PER, -2, 1);
      check_bit("R7 init low forces wide", bw_narrow, 1'b0);
      init_en = 1'b1;
      narrow_req = 1'b0;
      run_wave(5 * PER, -2, 1);
      check_bit("R8 request low gives wide", bw_narrow, 1'b0);
      narrow_req = 1'b1;
      run_wave(1, -2, 1);
      check_bit("R9 narrow returns with full run", bw_narrow, 1'b1);

      run_wave(10 * PER, 0, 0);                // feedback stopped
      check_bit("R6 stopped feedback sets loss", lock_lost, 1'b1);
      check_bit("R10 stopped feedback wide", bw_narrow, 1'b0);

      run_wave(20 * PER, 0, 1);                // coincident edges
      check_bit("R2 coincident edges lock", lock_lost, 1'b0);
      check_bit("R9 narrow after coincident run", bw_narrow, 1'b1);

      finish_run();
   end
endmodule